// File: doc/BRIEF.md
# Power-Fail Backup and Restore Sequencer

This controller decides when a battery-free memory module copies its SRAM image into nonvolatile cells and when it copies that image back. Two synchronised supply flags drive it. One means the supply is below the switch level, and the other means it is below the lower reset level. A one-cycle strobe reports each SRAM write, and two more strobes carry software store and recall requests. The block issues one-cycle start commands to the memory arrays. It also reports which step of the operation is running, drives an access-block line that stops all SRAM and clock accesses, and raises a busy flag.

A store runs an erase step and then a program step. A recall runs a clear step and then a transfer step. Each step lasts a number of clock cycles set by a parameter. This keeps simulation short and lets silicon use the real millisecond-scale times. An automatic store on power loss happens only when the image holds a write that has not been saved. A recall on power return happens only when the supply went all the way below the reset level. The clock registers are not part of either operation.

Top module: `pfail_nv_ctrl`

## Requirements
- R1: Out of reset the block is in a powered-down hold state with a recall pending: access_block=1, busy=0, step=0. The first time below_switch is low, a recall runs.
- R2: access_block is 1 in the same cycle as below_switch=1. It is also 1 whenever an operation or the powered-down hold is active.
- R3: When the block is idle and samples below_switch=1 with an unsaved write, it starts a store: store_start pulses in the next cycle.
- R4: When the block is idle and samples below_switch=1 with no unsaved write, it starts no store and enters the powered-down hold (step=0, busy=0).
- R5: A software store request sampled while idle with the supply good always starts a store, even with no unsaved write.
- R6: A software recall request sampled while idle with the supply good starts a recall. A store request in the same cycle takes priority.
- R7: below_reset=1 in any cycle latches a recall. The latched recall starts (recall_start pulse) in the cycle after below_switch is first sampled low again.
- R8: A supply dip that keeps below_reset=0 leads back to idle with no recall.
- R9: Step encoding is 0 idle or hold, 1 erase, 2 program, 3 clear, 4 transfer. Erase lasts ERASE_CYC cycles and is then followed by program for PROG_CYC cycles. Clear lasts CLEAR_CYC cycles and is then followed by transfer for XFER_CYC cycles. busy is 1 exactly during steps 1 to 4.
- R10: The unsaved-write flag is cleared when any store or recall finishes. Write strobes that arrive while access_block=1 do not set it.
- R11: Software requests are ignored while busy or while below_switch=1. The priority order is power loss, then a pending recall, then a software store, then a software recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_switch | input | 1 | Supply below switch threshold (synchronised) |
| below_reset | input | 1 | Supply below reset threshold (synchronised) |
| sram_wr | input | 1 | One-cycle strobe per SRAM write |
| sw_store | input | 1 | Software store request strobe |
| sw_recall | input | 1 | Software recall request strobe |
| store_start | output | 1 | One-cycle pulse on the first erase cycle |
| recall_start | output | 1 | One-cycle pulse on the first clear cycle |
| access_block | output | 1 | Blocks SRAM and clock accesses |
| busy | output | 1 | A store or recall is running |
| nv_step | output | 3 | Current step code (see R9) |

## Verification
access_block follows below_switch in the same cycle, with no register in the path. Every other result comes from the state register, so it appears one clock after the input sample that caused it. For example, store_start and recall_start are high in the cycle after the deciding edge, and each step code holds for exactly its parameter count of cycles. The bench reference model advances at the rising edge using the inputs as they were sampled there. It compares all outputs at the falling edge of the same cycle, so each result is checked in the cycle it is due. Scenario checks count start pulses over windows long enough for a whole operation to finish.

// File: rtl/pfail_nv_ctrl.sv
module pfail_nv_ctrl #(
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6,
  parameter int CLEAR_CYC = 3,
  parameter int XFER_CYC  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_switch,
  input  logic       below_reset,
  input  logic       sram_wr,
  input  logic       sw_store,
  input  logic       sw_recall,
  output logic       store_start,
  output logic       recall_start,
  output logic       access_block,
  output logic       busy,
  output logic [2:0] nv_step
);
  localparam int MAX_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_B = (CLEAR_CYC > XFER_CYC) ? CLEAR_CYC : XFER_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ERASE = 3'd1, S_PROG = 3'd2,
    S_CLEAR = 3'd3, S_XFER = 3'd4, S_DOWN = 3'd5
  } st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             recall_pend, dirty;

  wire last        = (cnt == '0);
  wire done        = ((st == S_PROG) || (st == S_XFER)) && last;
  wire enter_rcl   = (nxt == S_CLEAR) && (st != S_CLEAR);

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:
        if (below_switch)    nxt = dirty ? S_ERASE : S_DOWN;
        else if (recall_pend) nxt = S_CLEAR;
        else if (sw_store)    nxt = S_ERASE;
        else if (sw_recall)   nxt = S_CLEAR;
      S_ERASE: if (last) nxt = S_PROG;
      S_PROG:  if (last) nxt = S_IDLE;
      S_CLEAR: if (last) nxt = S_XFER;
      S_XFER:  if (last) nxt = S_IDLE;
      S_DOWN:  if (!below_switch) nxt = recall_pend ? S_CLEAR : S_IDLE;
      default: nxt = S_DOWN;
    endcase
  end

  always_comb begin
    nxt_cnt = last ? cnt : cnt - 1'b1;
    if (nxt != st) begin
      unique case (nxt)
        S_ERASE: nxt_cnt = CNT_W'(ERASE_CYC - 1);
        S_PROG:  nxt_cnt = CNT_W'(PROG_CYC - 1);
        S_CLEAR: nxt_cnt = CNT_W'(CLEAR_CYC - 1);
        S_XFER:  nxt_cnt = CNT_W'(XFER_CYC - 1);
        default: nxt_cnt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_DOWN;
      cnt         <= '0;
      recall_pend <= 1'b1;
      dirty       <= 1'b0;
    end else begin
      st          <= nxt;
      cnt         <= nxt_cnt;
      recall_pend <= below_reset | (recall_pend & ~enter_rcl);
      dirty       <= done ? 1'b0 : (dirty | (sram_wr & ~access_block));
    end
  end

  assign store_start  = (st == S_ERASE) && (cnt == CNT_W'(ERASE_CYC - 1));
  assign recall_start = (st == S_CLEAR) && (cnt == CNT_W'(CLEAR_CYC - 1));
  assign access_block = below_switch | (st != S_IDLE);
  assign busy         = (st == S_ERASE) || (st == S_PROG) ||
                        (st == S_CLEAR) || (st == S_XFER);
  assign nv_step      = (st == S_DOWN) ? 3'd0 : 3'(st);
endmodule

// File: rtl/pfail_nv_ctrl_chk.sv
module pfail_nv_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       below_switch,
  input logic       store_start,
  input logic       recall_start,
  input logic       access_block,
  input logic       busy,
  input logic [2:0] nv_step
);
  // R2
  block_on_low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_switch |-> access_block);
  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> access_block);
  // R3
  store_pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> (nv_step == 3'd1) ##1 !store_start);
  // R7
  recall_pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> (nv_step == 3'd3) ##1 !recall_start);
  // R9
  erase_then_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_step == 3'd1) |=> (nv_step == 3'd1) || (nv_step == 3'd2));
  // R9
  clear_then_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_step == 3'd3) |=> (nv_step == 3'd3) || (nv_step == 3'd4));
  // R11
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));
endmodule

bind pfail_nv_ctrl pfail_nv_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .below_switch(below_switch),
  .store_start(store_start), .recall_start(recall_start),
  .access_block(access_block), .busy(busy), .nv_step(nv_step)
);

// File: tb/sim_pfail_nv_ctrl.sv
`timescale 1ns/1ps
module sim_pfail_nv_ctrl;
  localparam int E = 4, P = 6, C = 3, X = 5;
  logic clk = 0, rst_n = 0;
  logic below_switch = 1, below_reset = 1, sram_wr = 0, sw_store = 0, sw_recall = 0;
  logic store_start, recall_start, access_block, busy;
  logic [2:0] nv_step;
  int checks = 0, fails = 0, ns = 0, nr = 0;
  bit run_cmp = 0;

  always #2.5 clk = ~clk;

  pfail_nv_ctrl #(.ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C), .XFER_CYC(X)) u0 (
    .clk(clk), .rst_n(rst_n), .below_switch(below_switch), .below_reset(below_reset),
    .sram_wr(sram_wr), .sw_store(sw_store), .sw_recall(sw_recall),
    .store_start(store_start), .recall_start(recall_start),
    .access_block(access_block), .busy(busy), .nv_step(nv_step));

  // reference model: mode 0 idle, 1 erase, 2 program, 3 clear, 4 transfer, 5 hold
  int mode = 5, left = 0;
  bit m_pend = 1, m_dirty = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 5; m_pend = 1; m_dirty = 0; left = 0;
    end else begin
      bit np, nd, blk;
      blk = (mode != 0) || below_switch;
      np = m_pend; nd = m_dirty | (sram_wr && !blk);
      case (mode)
        0: if (below_switch) begin
             if (m_dirty) begin mode = 1; left = E; end else mode = 5;
           end else if (m_pend) begin mode = 3; left = C; np = 0; end
           else if (sw_store) begin mode = 1; left = E; end
           else if (sw_recall) begin mode = 3; left = C; end
        1: begin left--; if (left == 0) begin mode = 2; left = P; end end
        2: begin left--; if (left == 0) begin mode = 0; nd = 0; end end
        3: begin left--; if (left == 0) begin mode = 4; left = X; end end
        4: begin left--; if (left == 0) begin mode = 0; nd = 0; end end
        default: if (!below_switch) begin
             if (m_pend) begin mode = 3; left = C; np = 0; end else mode = 0;
           end
      endcase
      m_pend = np | below_reset;
      m_dirty = nd;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (store_start) ns++;
    if (recall_start) nr++;
    if (run_cmp) begin
      chk("R2 access_block", access_block, (mode != 0) || below_switch);
      chk("R9 busy", busy, (mode >= 1 && mode <= 4));
      chk("R9 nv_step", nv_step, (mode == 5) ? 0 : mode);
      chk("R3 store_start", store_start, (mode == 1 && left == E));
      chk("R7 recall_start", recall_start, (mode == 3 && left == C));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s0, r0;
    step(3); rst_n = 1; run_cmp = 1;
    @(negedge clk);
    chk("R1 reset access_block", access_block, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset nv_step", nv_step, 0);
    step(2); below_reset = 0; step(2); below_switch = 0; step(20);
    chk("R1 power-up recall count", nr, 1);

    s0 = ns; r0 = nr;
    pulse(sram_wr); step(2); below_switch = 1;
    @(negedge clk); chk("R2 same-cycle block", access_block, 1);
    step(20); chk("R3 autostore after write", ns, s0 + 1);
    below_switch = 0; step(20); chk("R8 brownout no recall", nr, r0);

    s0 = ns; below_switch = 1; step(20);
    chk("R4 no store when clean", ns, s0);
    chk("R4 hold step", nv_step, 0);
    pulse(sram_wr); below_switch = 0; step(5);
    below_switch = 1; step(20); chk("R10 blocked write ignored", ns, s0);
    below_switch = 0; step(5);

    s0 = ns; pulse(sw_store); step(20); chk("R5 sw store when clean", ns, s0 + 1);

    s0 = ns; pulse(sram_wr); step(1); pulse(sw_store); step(20);
    below_switch = 1; step(20);
    chk("R10 dirty cleared by store", ns, s0 + 1);
    below_switch = 0; step(5);

    r0 = nr; pulse(sw_recall); step(20); chk("R6 sw recall", nr, r0 + 1);

    s0 = ns; r0 = nr; sw_store = 1; sw_recall = 1; step(1); sw_store = 0; sw_recall = 0;
    step(20); chk("R6 store wins over recall", ns, s0 + 1); chk("R6 recall lost", nr, r0);

    s0 = ns; r0 = nr; pulse(sw_store); step(2); pulse(sw_recall); step(20);
    chk("R11 store while busy", ns, s0 + 1); chk("R11 recall ignored while busy", nr, r0);
    s0 = ns; below_switch = 1; step(2); pulse(sw_store); step(20);
    chk("R11 store ignored at low supply", ns, s0);
    below_switch = 0; step(5);

    r0 = nr; below_switch = 1; step(2); below_reset = 1; step(3); below_reset = 0; step(3);
    chk("R7 no recall while low", nr, r0);
    below_switch = 0; step(20); chk("R7 recall after deep dip", nr, r0 + 1);

    summary();
  end
endmodule